// File: doc/BRIEF.md
# Dataflow Instruction Firing Element

This block is a small processing element for a dataflow fabric. It keeps a few static instructions in slots. Each instruction collects its operands from a stream of incoming value tokens and fires once all the operands it needs are there. Execution order comes from when operands arrive, not from a program counter. Several resident instructions can be ready at the same time. A round-robin selector lets one of them into the single ALU each cycle.

Each firing produces one result. A result addressed to a remote consumer is queued as a tagged token on the output channel, naming a destination slot and operand. A result marked local is written straight back into an operand register of a slot in this element, so a dependent instruction placed in the same element never uses the output queue. Software sets up a slot through the load port with an opcode and a destination. The slot then stays armed: each time it fires, its operands are consumed and it waits for a fresh pair.

Top module: `dfe_core`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1 for every target. A slot that has never been loaded never fires, even when both of its operands are present.
- R2: A load (`ld_en` high for one cycle) marks the slot as holding an instruction, stores its opcode and destination, and clears both of its operand-present bits.
- R3: Opcodes on `ld_op`: 0 add (a+b), 1 subtract (a-b), 2 AND, 3 OR, 4 XOR, 5 shift left a by b[4:0], 6 logical shift right a by b[4:0], 7 pass (result is a). Operand a is operand index 0 and operand b is operand index 1.
- R4: A slot is ready when it is loaded and operand 0 is present and, unless its opcode is pass, operand 1 is also present. A binary slot holding only operand 0 does not fire.
- R5: At most one slot fires in any cycle.
- R6: When several slots are eligible, the grant goes to the first eligible slot after the one that fired last, in increasing index order with wrap-around. After reset the search starts at slot 0.
- R7: Firing clears both present bits of the fired slot, so the same instruction fires again on the next set of operands.
- R8: An input token names a slot (`in_slot`), an operand (`in_opnd`, 0 or 1) and a 32-bit value. It is accepted (`in_ready` high) only when that operand is absent. A token aimed at a present operand waits until the operand is consumed. An accepted token sets the operand's present bit.
- R9: A non-local result whose output queue is full does not fire. The slot waits, and no result is lost. Queued results leave in the order they were produced.
- R10: A result whose destination is marked local (`ld_dst_local` = 1) is written into the named operand of the named slot in this element and produces no output token. It fires only when that operand is absent, or when the destination is the firing slot itself.
- R11: An output token carries the destination slot, destination operand and result value that were loaded with, and computed by, the instruction that fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load an instruction into a slot |
| ld_slot | input | 3 | Slot being loaded |
| ld_op | input | 3 | Opcode to load |
| ld_dst_slot | input | 3 | Destination slot of the result |
| ld_dst_opnd | input | 1 | Destination operand index of the result |
| ld_dst_local | input | 1 | 1: result loops back into this element |
| in_valid | input | 1 | Operand token offered |
| in_ready | output | 1 | Operand token accepted this cycle |
| in_slot | input | 3 | Target slot of the token |
| in_opnd | input | 1 | Target operand of the token |
| in_data | input | 32 | Token value |
| out_valid | output | 1 | Result token available |
| out_ready | input | 1 | Consumer takes the result token |
| out_slot | output | 3 | Destination slot carried by the result |
| out_opnd | output | 1 | Destination operand carried by the result |
| out_data | output | 32 | Result value |

## Verification
The hardest case to reach from the ports is several slots being ready at once. Normally each slot fires in the cycle after its last operand arrives, so tokens sent one at a time never compete. The stimulus holds `out_ready` low until the output queue is full, which stalls firing. It then completes operands for four slots in an order different from the expected round-robin order, and drains the queue one token at a time. The sequence of destination tags then shows both the grant order and that nothing was dropped. The local loop-back path is checked by a two-instruction chain in which only the consumer's token may appear at the output.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_SHL  = 3'd5,
        OP_SHR  = 3'd6,
        OP_PASS = 3'd7
    } dfe_op_e;

    // Single-operand opcodes need only operand 0.
    function automatic logic op_needs_b(dfe_op_e op);
        return op != OP_PASS;
    endfunction

endpackage

// File: rtl/dfe_alu.sv
module dfe_alu
    import dfe_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  dfe_op_e            op,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    output logic [DATA_W-1:0]  y
);
    localparam int SHW = $clog2(DATA_W);

    logic [SHW-1:0] shamt;
    assign shamt = b[SHW-1:0];

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SHL:  y = a << shamt;
            OP_SHR:  y = a >> shamt;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/dfe_rr_arb.sv
module dfe_rr_arb #(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic                 gnt_vld,
    output logic [$clog2(N)-1:0] gnt_idx
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [IW-1:0] last;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int off = 1; off <= N; off++) begin
            if (!gnt_vld && req[IW'((int'(st_q.last) + off) % N)]) begin
                gnt_vld = 1'b1;
                gnt_idx = IW'((int'(st_q.last) + off) % N);
            end
        end
        if (gnt_vld) st_d.last = gnt_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{last: IW'(N - 1)};
        else        st_q <= st_d;
    end

    // R6
    gnt_is_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> req[gnt_idx])
        else $error("grant to a slot that did not request");

    // R6
    no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> gnt_vld)
        else $error("requests pending but no grant");
endmodule

// File: rtl/dfe_outq.sv
module dfe_outq #(
    parameter int W     = 36,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } q_st_t;

    q_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (st_q.cnt == (AW+1)'(DEPTH));
    assign empty    = (st_q.cnt == '0);
    assign pop_data = mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = bump(st_q.wp);
        if (pop)  st_d.rp = bump(st_q.rp);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wp] <= push_data;
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full)
        else $error("result pushed into a full queue");

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty)
        else $error("pop from an empty queue");
endmodule

// File: rtl/dfe_core.sv
module dfe_core
    import dfe_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int DATA_W     = 32,
    parameter int OUTQ_DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_en,
    input  logic [$clog2(NUM_SLOTS)-1:0] ld_slot,
    input  logic [2:0]                   ld_op,
    input  logic [$clog2(NUM_SLOTS)-1:0] ld_dst_slot,
    input  logic                         ld_dst_opnd,
    input  logic                         ld_dst_local,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [$clog2(NUM_SLOTS)-1:0] in_slot,
    input  logic                         in_opnd,
    input  logic [DATA_W-1:0]            in_data,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [$clog2(NUM_SLOTS)-1:0] out_slot,
    output logic                         out_opnd,
    output logic [DATA_W-1:0]            out_data
);
    localparam int SW    = $clog2(NUM_SLOTS);
    localparam int TOK_W = SW + 1 + DATA_W;

    typedef struct packed {
        logic [NUM_SLOTS-1:0]             vld;
        logic [NUM_SLOTS-1:0]             pa;
        logic [NUM_SLOTS-1:0]             pb;
        logic [NUM_SLOTS-1:0][2:0]        op;
        logic [NUM_SLOTS-1:0][SW-1:0]     dslot;
        logic [NUM_SLOTS-1:0]             dopnd;
        logic [NUM_SLOTS-1:0]             dloc;
        logic [NUM_SLOTS-1:0][DATA_W-1:0] va;
        logic [NUM_SLOTS-1:0][DATA_W-1:0] vb;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [NUM_SLOTS-1:0] elig;
    logic                 fire_vld;
    logic [SW-1:0]        fire_idx;
    logic                 fire_loc;
    logic                 push;
    logic [SW-1:0]        loc_slot;
    logic                 loc_opnd;
    logic [DATA_W-1:0]    alu_y;
    logic                 q_full;
    logic                 q_empty;
    logic [TOK_W-1:0]     q_head;
    logic                 tok_take;

    // Per-slot eligibility: ready operands and a free path for the result.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic rdy;
        logic tgt_busy;
        assign rdy = st_q.vld[i] & st_q.pa[i]
                   & (st_q.pb[i] | !op_needs_b(dfe_op_e'(st_q.op[i])));
        assign tgt_busy = (st_q.dslot[i] != SW'(i)) &
                          (st_q.dopnd[i] ? st_q.pb[st_q.dslot[i]]
                                         : st_q.pa[st_q.dslot[i]]);
        assign elig[i] = rdy & (st_q.dloc[i] ? !tgt_busy : !q_full);
    end

    dfe_rr_arb #(.N(NUM_SLOTS)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (elig),
        .gnt_vld (fire_vld),
        .gnt_idx (fire_idx)
    );

    dfe_alu #(.DATA_W(DATA_W)) u_alu (
        .op (dfe_op_e'(st_q.op[fire_idx])),
        .a  (st_q.va[fire_idx]),
        .b  (st_q.vb[fire_idx]),
        .y  (alu_y)
    );

    assign loc_slot = st_q.dslot[fire_idx];
    assign loc_opnd = st_q.dopnd[fire_idx];
    assign fire_loc = fire_vld &  st_q.dloc[fire_idx];
    assign push     = fire_vld & !st_q.dloc[fire_idx];

    assign in_ready = !(in_opnd ? st_q.pb[in_slot] : st_q.pa[in_slot])
                    && !(ld_en && ld_slot == in_slot)
                    && !(fire_loc && loc_slot == in_slot && loc_opnd == in_opnd);
    assign tok_take = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (fire_vld) begin
            st_d.pa[fire_idx] = 1'b0;
            st_d.pb[fire_idx] = 1'b0;
        end
        if (fire_loc) begin
            if (loc_opnd) begin
                st_d.vb[loc_slot] = alu_y;
                st_d.pb[loc_slot] = 1'b1;
            end else begin
                st_d.va[loc_slot] = alu_y;
                st_d.pa[loc_slot] = 1'b1;
            end
        end
        if (tok_take) begin
            if (in_opnd) begin
                st_d.vb[in_slot] = in_data;
                st_d.pb[in_slot] = 1'b1;
            end else begin
                st_d.va[in_slot] = in_data;
                st_d.pa[in_slot] = 1'b1;
            end
        end
        if (ld_en) begin
            st_d.vld[ld_slot]   = 1'b1;
            st_d.op[ld_slot]    = ld_op;
            st_d.dslot[ld_slot] = ld_dst_slot;
            st_d.dopnd[ld_slot] = ld_dst_opnd;
            st_d.dloc[ld_slot]  = ld_dst_local;
            st_d.pa[ld_slot]    = 1'b0;
            st_d.pb[ld_slot]    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dfe_outq #(.W(TOK_W), .DEPTH(OUTQ_DEPTH)) u_outq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data ({loc_slot, loc_opnd, alu_y}),
        .full      (q_full),
        .pop       (out_valid && out_ready),
        .pop_data  (q_head),
        .empty     (q_empty)
    );

    assign out_valid = !q_empty;
    assign out_slot  = q_head[TOK_W-1 -: SW];
    assign out_opnd  = q_head[DATA_W];
    assign out_data  = q_head[DATA_W-1:0];

    // R7
    clear_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_vld && !(fire_loc && loc_slot == fire_idx && !loc_opnd))
        |=> !st_q.pa[$past(fire_idx)])
        else $error("operand 0 still present after firing");

    // R8
    tok_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_take |=> ($past(in_opnd) ? st_q.pb[$past(in_slot)]
                                     : st_q.pa[$past(in_slot)]))
        else $error("accepted token did not set its operand");

    // R10
    loop_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_loc && !(ld_en && ld_slot == loc_slot))
        |=> ($past(loc_opnd) ? st_q.pb[$past(loc_slot)]
                             : st_q.pa[$past(loc_slot)]))
        else $error("local result did not reach its operand");

    // R1
    unloaded_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_vld |-> st_q.vld[fire_idx])
        else $error("an unloaded slot fired");
endmodule

// File: tb/dfe_core_tb_top.sv
`timescale 1ns/1ps
module dfe_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_slot = '0;
    logic [2:0]  ld_op = '0;
    logic [2:0]  ld_dst_slot = '0;
    logic        ld_dst_opnd = 1'b0;
    logic        ld_dst_local = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_slot = '0;
    logic        in_opnd = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [2:0]  out_slot;
    logic        out_opnd;
    logic [31:0] out_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dfe_core dut_i (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_slot(ld_slot), .ld_op(ld_op),
        .ld_dst_slot(ld_dst_slot), .ld_dst_opnd(ld_dst_opnd), .ld_dst_local(ld_dst_local),
        .in_valid(in_valid), .in_ready(in_ready), .in_slot(in_slot),
        .in_opnd(in_opnd), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_slot(out_slot),
        .out_opnd(out_opnd), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input int op, input logic [31:0] a,
                                          input logic [31:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return a << b[4:0];
            6: return a >> b[4:0];
            default: return a;
        endcase
    endfunction

    task automatic load(input int slot, input int op, input int dslot,
                        input bit dopnd, input bit dloc);
        @(negedge clk);
        ld_en = 1'b1; ld_slot = 3'(slot); ld_op = 3'(op);
        ld_dst_slot = 3'(dslot); ld_dst_opnd = dopnd; ld_dst_local = dloc;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic send(input int slot, input bit opnd, input logic [31:0] val);
        int guard = 0;
        @(negedge clk);
        in_valid = 1'b1; in_slot = 3'(slot); in_opnd = opnd; in_data = val;
        #1;
        while (!in_ready && guard < 200) begin
            @(negedge clk); #1;
            guard++;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic pop(output logic [2:0] s, output logic o,
                       output logic [31:0] d, output bit got);
        got = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (out_valid) begin got = 1'b1; break; end
        end
        s = out_slot; o = out_opnd; d = out_data;
        if (got) begin
            out_ready = 1'b1;
            @(posedge clk); #1;
            out_ready = 1'b0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'(0));
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'(1));
    endtask

    task automatic t_unloaded();
        logic [2:0] s; logic o; logic [31:0] d; bit got;
        send(7, 0, 32'd9);
        send(7, 1, 32'd9);
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "unloaded slot must not fire", 64'(out_valid), 64'(0));
        @(negedge clk); in_slot = 3'd7; in_opnd = 1'b0; #1;
        chk(in_ready == 1'b0, "R8", "present operand blocks token", 64'(in_ready), 64'(0));
        load(7, 0, 3, 1'b1, 1'b0);
        @(negedge clk); in_slot = 3'd7; in_opnd = 1'b0; #1;
        chk(in_ready == 1'b1, "R2", "load clears operand presence", 64'(in_ready), 64'(1));
        send(7, 0, 32'd5);
        send(7, 1, 32'd6);
        pop(s, o, d, got);
        chk(got && s == 3'd3 && o == 1'b1, "R11", "dest tag (slot<<1|opnd)",
            64'({s, o}), 64'({3'd3, 1'b1}));
        chk(got && d == 32'd11, "R2", "loaded slot computes", 64'(d), 64'(11));
    endtask

    task automatic t_ops();
        logic [2:0] s; logic o; logic [31:0] d; bit got;
        logic [31:0] a, b;
        for (int op = 0; op < 8; op++) begin
            a = 32'hA5C3_0F18 + 32'(op * 7919);
            b = (op >= 5) ? 32'(35 + op) : 32'h3C6E_91B2 - 32'(op);
            load(0, op, 2, 1'b0, 1'b0);
            send(0, 0, a);
            if (op != 7) send(0, 1, b);
            pop(s, o, d, got);
            chk(got && d == model(op, a, b), (op == 7) ? "R4" : "R3",
                $sformatf("opcode %0d result", op), 64'(d), 64'(model(op, a, b)));
        end
    endtask

    task automatic t_need_b();
        logic [2:0] s; logic o; logic [31:0] d; bit got;
        load(1, 1, 2, 1'b0, 1'b0);
        send(1, 0, 32'd100);
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R4", "binary op waits for operand 1", 64'(out_valid), 64'(0));
        send(1, 1, 32'd30);
        pop(s, o, d, got);
        chk(got && d == 32'd70, "R4", "fires once operand 1 arrives", 64'(d), 64'(70));
    endtask

    task automatic t_hold();
        logic [2:0] s; logic o; logic [31:0] d; bit got;
        load(1, 0, 1, 1'b0, 1'b0);
        send(1, 0, 32'd10);
        @(negedge clk);
        in_valid = 1'b1; in_slot = 3'd1; in_opnd = 1'b0; in_data = 32'd20;
        repeat (3) @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "R8", "token to present operand held", 64'(in_ready), 64'(0));
        in_valid = 1'b0;
        send(1, 1, 32'd1);
        pop(s, o, d, got);
        chk(got && d == 32'd11, "R8", "original operand kept", 64'(d), 64'(11));
        send(1, 0, 32'd20);
        send(1, 1, 32'd2);
        pop(s, o, d, got);
        chk(got && d == 32'd22, "R7", "slot refires on new operands", 64'(d), 64'(22));
    endtask

    task automatic t_rr();
        logic [2:0] s; logic o; logic [31:0] d; bit got;
        int exp_s [8] = '{0, 1, 2, 3, 5, 6, 0, 2};
        int exp_d [8] = '{1, 11, 21, 31, 301, 101, 201, 401};
        for (int i = 0; i < 4; i++) load(i, 0, i, 1'b0, 1'b0);
        load(5, 0, 5, 1'b0, 1'b0);
        load(6, 0, 6, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            send(i, 0, 32'(i * 10));
            send(i, 1, 32'd1);
        end
        send(6, 0, 32'd100); send(6, 1, 32'd1);
        send(0, 0, 32'd200); send(0, 1, 32'd1);
        send(5, 0, 32'd300); send(5, 1, 32'd1);
        send(2, 0, 32'd400); send(2, 1, 32'd1);
        for (int k = 0; k < 8; k++) begin
            pop(s, o, d, got);
            chk(got && int'(s) == exp_s[k], (k < 4) ? "R9" : "R6",
                $sformatf("token %0d source slot", k), 64'(s), 64'(exp_s[k]));
            chk(got && d == 32'(exp_d[k]), "R9", $sformatf("token %0d value", k),
                64'(d), 64'(exp_d[k]));
        end
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R5", "no extra results", 64'(out_valid), 64'(0));
    endtask

    task automatic t_loop();
        logic [2:0] s; logic o; logic [31:0] d; bit got;
        load(5, 4, 6, 1'b1, 1'b0);
        load(4, 0, 5, 1'b0, 1'b1);
        send(5, 1, 32'h0000_F0F0);
        send(4, 0, 32'd3);
        send(4, 1, 32'd4);
        pop(s, o, d, got);
        chk(got && s == 3'd6 && o == 1'b1, "R10", "only consumer token leaves",
            64'({s, o}), 64'({3'd6, 1'b1}));
        chk(got && d == (32'd7 ^ 32'h0000_F0F0), "R10", "looped value used",
            64'(d), 64'(32'd7 ^ 32'h0000_F0F0));
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R10", "producer emits no token", 64'(out_valid), 64'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: all requirements, actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_unloaded();
        t_ops();
        t_need_b();
        t_hold();
        t_rr();
        t_loop();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule